// File: doc/BRIEF.md
# Multi-Plane Operation Pairing Classifier

This block looks at the operations waiting for one flash die that has several planes, one descriptor slot per plane. It decides whether they can go out as one multi-plane command or must be sent plane by plane. Each slot carries three things:

- a valid flag;
- a 2-bit operation kind: 0 read, 1 write, 2 erase;
- the page/block address inside the plane.

The block compares the kinds and in-plane addresses of the valid slots and reports one of four pairing cases. When every valid slot agrees, it asserts a merge grant and gives the mask of planes to issue together. Otherwise it points at the single plane to issue first.

The decision is combinational. It is registered once per clock, so the die scheduler sees a stable verdict one cycle after it presents a set of descriptors. Slots whose valid flag is low take no part in the comparison.

Top module: `plane_pair_classifier`

## Requirements
- R1: While reset is active, and on the first sample after it, caseValid, caseCode, mergeGrant and issueMask are all zero.
- R2: When no slot is valid, the next cycle shows caseValid=0, caseCode=0, mergeGrant=0 and issueMask=0.
- R3: When exactly one slot is valid, the next cycle shows caseValid=1, caseCode=0 (single), mergeGrant=0 and issueMask equal to that slot's bit.
- R4: When two or more slots are valid and their 2-bit kinds are not all equal, the next cycle shows caseCode=1 (mixed), mergeGrant=0 and issueMask holding only the lowest-numbered valid slot. Address differences do not change this result.
- R5: When two or more valid slots share one kind but their in-plane addresses are not all equal, the next cycle shows caseCode=2 (unaligned), mergeGrant=0 and issueMask holding only the lowest-numbered valid slot.
- R6: When two or more valid slots share one kind and one in-plane address, the next cycle shows caseCode=3 (parallel), mergeGrant=1 and issueMask equal to the full set of valid slots.
- R7: The kind and address of a slot whose valid flag is low have no effect on any output.
- R8: Each output set depends only on the descriptors sampled at the previous clock edge. Back-to-back descriptor sets therefore produce back-to-back verdicts with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | NUM_PLANES | Per-plane slot valid flags |
| opType | input | 2*NUM_PLANES | Per-plane kind, slot i at bits [2i+1:2i]; 0 read, 1 write, 2 erase |
| opAddr | input | ADDR_W*NUM_PLANES | Per-plane in-plane address, slot i at bits [ADDR_W*i +: ADDR_W] |
| caseValid | output | 1 | A verdict is present |
| caseCode | output | 2 | 0 single, 1 mixed, 2 unaligned, 3 parallel |
| mergeGrant | output | 1 | The slots in issueMask may go out as one multi-plane command |
| issueMask | output | NUM_PLANES | Planes to issue in the next command |

## Verification
Every output is due exactly one clock after the descriptors that produce it. There is a single register between the inputs and the ports. The bench changes descriptors on the falling edge and keeps the verdict it expects for them. On the next falling edge, after one rising edge has loaded the register, it compares all four outputs against that verdict. Only then does it apply the next set. Directed sets cover each case, including invalid slots carrying conflicting kinds and addresses. Random sets use a narrow address range, so aligned and unaligned pairs both occur often.

// File: rtl/plane_pair_pkg.sv
package plane_pair_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [1:0] {
    CASE_SINGLE    = 2'd0,
    CASE_MIXED     = 2'd1,
    CASE_UNALIGNED = 2'd2,
    CASE_PARALLEL  = 2'd3
  } pairCase_e;

  // Strobes from the comparison datapath to the decision control
  typedef struct packed {
    logic anyValid;
    logic multiValid;
    logic kindsAgree;
    logic addrsAgree;
  } cmpStrobe_t;

endpackage

// File: rtl/plane_pair_compare.sv
module plane_pair_compare
  import plane_pair_pkg::*;
#(
  parameter int NUM_PLANES = 2,
  parameter int ADDR_W     = 24
) (
  input  logic [NUM_PLANES-1:0]        opValid,
  input  logic [NUM_PLANES*KIND_W-1:0] opType,
  input  logic [NUM_PLANES*ADDR_W-1:0] opAddr,
  output cmpStrobe_t                   strobe,
  output logic [NUM_PLANES-1:0]        leadMask
);

  logic [KIND_W-1:0]     refKind;
  logic [ADDR_W-1:0]     refAddr;
  logic [NUM_PLANES-1:0] kindOk;
  logic [NUM_PLANES-1:0] addrOk;

  // Lowest-numbered valid slot acts as the reference
  assign leadMask = opValid & (~opValid + 1'b1);

  always_comb begin
    refKind = '0;
    refAddr = '0;
    for (int i = 0; i < NUM_PLANES; i++) begin
      refKind = refKind | ({KIND_W{leadMask[i]}} & opType[i*KIND_W +: KIND_W]);
      refAddr = refAddr | ({ADDR_W{leadMask[i]}} & opAddr[i*ADDR_W +: ADDR_W]);
    end
  end

  for (genvar g = 0; g < NUM_PLANES; g++) begin : gSlot
    assign kindOk[g] = !opValid[g] || (opType[g*KIND_W +: KIND_W] == refKind);
    assign addrOk[g] = !opValid[g] || (opAddr[g*ADDR_W +: ADDR_W] == refAddr);
  end

  assign strobe.anyValid   = |opValid;
  assign strobe.multiValid = (opValid & (opValid - 1'b1)) != '0;
  assign strobe.kindsAgree = &kindOk;
  assign strobe.addrsAgree = &addrOk;

endmodule

// File: rtl/plane_pair_decide.sv
module plane_pair_decide
  import plane_pair_pkg::*;
#(
  parameter int NUM_PLANES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cmpStrobe_t            strobe,
  input  logic [NUM_PLANES-1:0] opValid,
  input  logic [NUM_PLANES-1:0] leadMask,
  output logic                  caseValid,
  output pairCase_e             caseCode,
  output logic                  mergeGrant,
  output logic [NUM_PLANES-1:0] issueMask
);

  logic                  nxtValid;
  pairCase_e             nxtCode;
  logic                  nxtGrant;
  logic [NUM_PLANES-1:0] nxtMask;

  always_comb begin
    nxtValid = 1'b0;
    nxtCode  = CASE_SINGLE;
    nxtGrant = 1'b0;
    nxtMask  = '0;
    if (strobe.anyValid) begin
      nxtValid = 1'b1;
      if (!strobe.multiValid) begin
        nxtCode = CASE_SINGLE;
        nxtMask = opValid;
      end else if (!strobe.kindsAgree) begin
        nxtCode = CASE_MIXED;
        nxtMask = leadMask;
      end else if (!strobe.addrsAgree) begin
        nxtCode = CASE_UNALIGNED;
        nxtMask = leadMask;
      end else begin
        nxtCode  = CASE_PARALLEL;
        nxtGrant = 1'b1;
        nxtMask  = opValid;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      caseValid  <= 1'b0;
      caseCode   <= CASE_SINGLE;
      mergeGrant <= 1'b0;
      issueMask  <= '0;
    end else begin
      caseValid  <= nxtValid;
      caseCode   <= nxtCode;
      mergeGrant <= nxtGrant;
      issueMask  <= nxtMask;
    end
  end

endmodule

// File: rtl/plane_pair_classifier.sv
module plane_pair_classifier
  import plane_pair_pkg::*;
#(
  parameter int NUM_PLANES = 2,
  parameter int ADDR_W     = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PLANES-1:0]        opValid,
  input  logic [NUM_PLANES*KIND_W-1:0] opType,
  input  logic [NUM_PLANES*ADDR_W-1:0] opAddr,
  output logic                         caseValid,
  output logic [1:0]                   caseCode,
  output logic                         mergeGrant,
  output logic [NUM_PLANES-1:0]        issueMask
);

  cmpStrobe_t            strobe;
  logic [NUM_PLANES-1:0] leadMask;
  pairCase_e             codeQ;

  plane_pair_compare #(
    .NUM_PLANES(NUM_PLANES),
    .ADDR_W    (ADDR_W)
  ) u_compare (
    .opValid (opValid),
    .opType  (opType),
    .opAddr  (opAddr),
    .strobe  (strobe),
    .leadMask(leadMask)
  );

  plane_pair_decide #(
    .NUM_PLANES(NUM_PLANES)
  ) u_decide (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opValid   (opValid),
    .leadMask  (leadMask),
    .caseValid (caseValid),
    .caseCode  (codeQ),
    .mergeGrant(mergeGrant),
    .issueMask (issueMask)
  );

  assign caseCode = codeQ;

endmodule

// File: rtl/plane_pair_checker.sv
module plane_pair_checker #(
  parameter int NUM_PLANES = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PLANES-1:0] opValid,
  input logic                  caseValid,
  input logic [1:0]            caseCode,
  input logic                  mergeGrant,
  input logic [NUM_PLANES-1:0] issueMask
);

  // R6: a grant only accompanies the parallel case
  a_r6_grant_is_parallel: assert property (@(posedge clk) disable iff (!rstN)
    mergeGrant |-> (caseValid && caseCode == 2'd3));

  // R6: a granted command covers every slot that was valid
  a_r6_grant_mask: assert property (@(posedge clk) disable iff (!rstN)
    mergeGrant |-> (issueMask == $past(opValid)));

  // R2: an empty slot set yields an idle verdict
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    (opValid == '0) |=> (!caseValid && !mergeGrant && issueMask == '0));

  // R3: a lone valid slot is the single case on that plane
  a_r3_single: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(opValid) == 1) |=>
      (caseValid && caseCode == 2'd0 && !mergeGrant && issueMask == $past(opValid)));

  // R4/R5: a verdict without a grant names exactly one plane
  a_r5_serial_one_plane: assert property (@(posedge clk) disable iff (!rstN)
    (caseValid && !mergeGrant) |-> ($countones(issueMask) == 1));

  // R8: a verdict exists only if slots were valid one edge earlier
  a_r8_verdict_source: assert property (@(posedge clk) disable iff (!rstN)
    caseValid |-> ($past(opValid) != '0));

endmodule

bind plane_pair_classifier plane_pair_checker #(
  .NUM_PLANES(NUM_PLANES)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .caseValid (caseValid),
  .caseCode  (caseCode),
  .mergeGrant(mergeGrant),
  .issueMask (issueMask)
);

// File: tb/plane_pair_classifier_tb.sv
module plane_pair_classifier_tb;

  localparam int NP  = 2;
  localparam int AW  = 8;
  localparam time CLK = 20ns;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   vIn = '0;
  logic [NP*2-1:0] tIn = '0;
  logic [NP*AW-1:0] aIn = '0;
  logic            caseValid;
  logic [1:0]      caseCode;
  logic            mergeGrant;
  logic [NP-1:0]   issueMask;

  int checks = 0;
  int errors = 0;

  logic          eValid;
  logic [1:0]    eCode;
  logic          eGrant;
  logic [NP-1:0] eMask;
  string         eTag;

  always #(CLK/2) clk = ~clk;

  plane_pair_classifier #(.NUM_PLANES(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(vIn), .opType(tIn), .opAddr(aIn),
    .caseValid(caseValid), .caseCode(caseCode), .mergeGrant(mergeGrant),
    .issueMask(issueMask)
  );

  // Behavioural reference of the pairing verdict
  task automatic model(input logic [NP-1:0] v, input logic [NP*2-1:0] t,
                       input logic [NP*AW-1:0] a);
    int cnt = 0;
    int lead = -1;
    bit mixed = 0;
    bit unal = 0;
    for (int i = 0; i < NP; i++) begin
      if (v[i]) begin
        cnt++;
        if (lead < 0) lead = i;
      end
    end
    eValid = 0; eCode = 0; eGrant = 0; eMask = '0;
    if (cnt == 1) begin
      eValid = 1; eMask = v;
    end else if (cnt > 1) begin
      for (int i = 0; i < NP; i++) begin
        if (v[i]) begin
          if (t[i*2 +: 2] != t[lead*2 +: 2]) mixed = 1;
          if (a[i*AW +: AW] != a[lead*AW +: AW]) unal = 1;
        end
      end
      eValid = 1;
      if (mixed) begin eCode = 1; eMask = NP'(1) << lead; end
      else if (unal) begin eCode = 2; eMask = NP'(1) << lead; end
      else begin eCode = 3; eGrant = 1; eMask = v; end
    end
  endtask

  function automatic string tagFor();
    if (!eValid) return "R2";
    case (eCode)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (caseValid !== eValid || caseCode !== eCode || mergeGrant !== eGrant ||
        issueMask !== eMask) begin
      errors++;
      $display("FAIL %s: got valid=%0b code=%0d grant=%0b mask=%b expected valid=%0b code=%0d grant=%0b mask=%b",
               eTag, caseValid, caseCode, mergeGrant, issueMask, eValid, eCode, eGrant, eMask);
    end
  endtask

  // Check the verdict of the previous set, then apply a new one
  task automatic step(input logic [NP-1:0] v, input logic [NP*2-1:0] t,
                      input logic [NP*AW-1:0] a, input string tag);
    @(negedge clk);
    compare();
    vIn = v; tIn = t; aIn = a;
    model(v, t, a);
    eTag = (tag == "") ? tagFor() : tag;
  endtask

  initial begin
    #(CLK * 150000);
    errors++;
    $display("FAIL watchdog: got no end expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs stay idle under reset even with valid slots present
    vIn = 2'b11; tIn = 4'b0101; aIn = {8'd5, 8'd5};
    eValid = 0; eCode = 0; eGrant = 0; eMask = '0; eTag = "R1";
    repeat (3) @(negedge clk);
    compare();
    vIn = '0;
    rstN = 1'b1;
    @(negedge clk);
    compare();

    // Directed sets: {plane1, plane0}
    step(2'b00, 4'b1001, {8'd1, 8'd2}, "R2");
    step(2'b01, 4'b0000, {8'd9, 8'd3}, "R3");
    step(2'b10, 4'b0100, {8'd7, 8'd7}, "R3");
    step(2'b11, 4'b0100, {8'd4, 8'd4}, "R4");   // read vs write, same address
    step(2'b11, 4'b1000, {8'd1, 8'd2}, "R4");   // erase vs read, differing address
    step(2'b11, 4'b0101, {8'd3, 8'd8}, "R5");   // write/write unaligned
    step(2'b11, 4'b1010, {8'd6, 8'd6}, "R6");   // erase/erase aligned
    step(2'b11, 4'b0000, {8'd0, 8'd0}, "R6");   // read/read aligned at zero
    // R7: invalid slot carries a clashing kind and address
    step(2'b01, 4'b1001, {8'd200, 8'd17}, "R7");
    step(2'b10, 4'b0110, {8'd33, 8'd90}, "R7");
    step(2'b00, 4'b1101, {8'd1, 8'd2}, "R7");
    // R8: back-to-back changes, every verdict one cycle later
    step(2'b11, 4'b0101, {8'd12, 8'd12}, "R8");
    step(2'b11, 4'b0101, {8'd12, 8'd13}, "R8");
    step(2'b11, 4'b0100, {8'd12, 8'd12}, "R8");
    step(2'b00, 4'b0000, {8'd0, 8'd0}, "R8");

    // Random sets with a narrow address range
    for (int n = 0; n < 400; n++) begin
      logic [NP-1:0]    v;
      logic [NP*2-1:0]  t;
      logic [NP*AW-1:0] a;
      v = NP'($urandom_range(0, (1 << NP) - 1));
      for (int i = 0; i < NP; i++) begin
        t[i*2 +: 2]   = 2'($urandom_range(0, 2));
        a[i*AW +: AW] = AW'($urandom_range(0, 2));
      end
      step(v, t, a, "");
    end
    @(negedge clk);
    compare();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule